// File: doc/BRIEF.md
# Variable-Rate Playback Slot Request Generator

This block sits on the codec side of a serial audio link whose frames run at a fixed 48 kHz. Once per frame it decides which playback slots must ask the controller for a fresh sample. It drives one active-low request bit per slot for the next input frame. When the following output frame arrives, it checks that frame's tag bits. A requested slot that comes back tagged has its sample pushed into a small per-slot FIFO. The DAC side drains that FIFO at its own pace.

With variable-rate operation off, every active slot requests in every frame, so the effective rate is the frame rate. With it on, each slot has its own programmed rate in Hz. A phase accumulator turns that rate into evenly spaced requests. For example, a 44100 Hz stream asks for a sample in exactly 441 of every 480 frames. A request is held back when the FIFO could not take the sample it would bring. A requested sample that arrives untagged is recorded as a sticky underrun.

The register bus, the serial shifter and the DAC datapath are outside this block. Rates are written through a simple parallel write port, and all per-slot signals are parallel vectors.

Top module: `vra_slot_pacer`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has every slot_req_n bit at 1, every fifo_level at 0, every underrun bit at 0 and every fifo_wr bit at 0.
- R2: When vra_en is 0 at a frame_strb edge, every active slot drives its slot_req_n bit to 0 from that edge, whatever its FIFO level.
- R3: When vra_en is 1, each active slot adds its rate to a phase accumulator at every frame_strb edge. When the sum reaches 48000 or more, the slot requests (bit 0) and 48000 is subtracted. Otherwise the bit is 1 and the sum is kept. Starting from a cleared accumulator, 480 frames at 44100 give exactly 441 requests, and at 8000 they give exactly 80.
- R4: A rate write (rate_we with rate_wsel selecting the slot index) is stored only while vra_en is 1. The reset rate is 48000. A written value above 48000 behaves as 48000, which is a request every frame.
- R5: A slot that is powered down (slot_pdn bit 1) or not set in SLOT_MASK drives slot_req_n high at every frame_strb edge. Its accumulator is cleared, so it restarts from zero when it is powered up.
- R6: When vra_en is 1, a slot whose FIFO level after the current edge would equal the depth does not request. Its accumulator is held, and it requests again on the first frame after room appears.
- R7: At a frame_strb edge, an active slot whose slot_req_n bit was 0 and whose tag_in bit is 1 pushes its slot_din word into the FIFO, provided there is room. fifo_wr for that slot is 1 in the cycle after the edge.
- R8: A tag_in bit on a slot whose slot_req_n bit was 1 is ignored: no FIFO write and no fifo_wr pulse.
- R9: At a frame_strb edge, a requested active slot with tag_in 0 sets its underrun bit. That bit stays 1 until reset, and no write occurs.
- R10: A dac_pop on a non-empty FIFO removes the oldest word. dac_dout always shows the oldest word. A pop on an empty FIFO is ignored.
- R11: slot_req_n changes only at a frame_strb edge and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strb | input | 1 | One-cycle pulse at the start of each output frame |
| vra_en | input | 1 | Variable-rate enable |
| rate_we | input | 1 | Rate write strobe |
| rate_wsel | input | SEL_W | Slot index for the rate write |
| rate_wdata | input | RATE_W | Rate in Hz to write |
| slot_pdn | input | NUM_SLOTS | Per-slot power-down flags |
| tag_in | input | NUM_SLOTS | Tag bits of the incoming output frame, valid with frame_strb |
| slot_din | input | NUM_SLOTS*DATA_W | Incoming sample per slot, valid with frame_strb |
| dac_pop | input | NUM_SLOTS | DAC-side FIFO read strobes |
| slot_req_n | output | NUM_SLOTS | Active-low request bits for the next input frame |
| fifo_wr | output | NUM_SLOTS | One-cycle strobe after a tagged sample is accepted |
| dac_dout | output | NUM_SLOTS*DATA_W | Oldest FIFO word per slot |
| fifo_level | output | NUM_SLOTS*LVL_W | FIFO fill level per slot |
| underrun | output | NUM_SLOTS | Sticky missing-sample flags |

## Verification
The bench checks the exact request count over a full 480-frame cycle at 44100 Hz and at 8000 Hz. A design with an off-by-one threshold (greater-than instead of at-least) or with bursty pacing would miss these counts. It fills a FIFO without draining it to confirm that the request stops exactly at the depth and then resumes after a single pop. A design that tests room before counting the sample in flight would overflow, and one that discards the phase credit would lose a request. It sends tags on slots that never asked, to catch a design that writes them anyway. It withholds tags on slots that did ask, to catch an underrun flag that is missing or that clears itself. It also writes rates while variable-rate operation is off, to catch a design that lets those writes through and so paces at the wrong rate later.

// File: rtl/vra_pkg.sv
// Package: shared types and helpers for the variable-rate slot request generator.
// Assumes: nothing beyond IEEE 1800-2017.
package vra_pkg;

    // Per-frame pacing decision of one slot.
    typedef enum logic [2:0] {
        PACE_OFF,     // slot inactive: no request, accumulator cleared
        PACE_FORCED,  // fixed-rate mode: request every frame
        PACE_FIRE,    // phase wrapped and FIFO has room: request
        PACE_STALL,   // phase wrapped but FIFO full: hold phase
        PACE_WAIT     // phase below the wrap point: accumulate
    } pace_t;

    // Width that holds any sum of an accumulator value and a clamped rate.
    function automatic int acc_width(input int frame_hz);
        return $clog2(2 * frame_hz);
    endfunction

    // Width of a slot index, at least one bit.
    function automatic int index_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/vra_rate_regs.sv
// Module: per-slot sample-rate registers.
// Stores one rate per slot. A write is taken only while variable-rate mode is on,
// and values above the frame rate are clamped to it. The effective rate falls back
// to the frame rate while variable-rate mode is off.
// Assumes: FRAME_HZ fits in RATE_W bits.
module vra_rate_regs #(
    parameter int NUM_SLOTS = 2,
    parameter int RATE_W    = 16,
    parameter int FRAME_HZ  = 48000,
    parameter int SEL_W     = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vra_en,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [RATE_W-1:0]             wr_data,
    output logic [NUM_SLOTS*RATE_W-1:0]   eff_rate
);

    localparam logic [RATE_W-1:0] FULL_RATE = RATE_W'(FRAME_HZ);

    logic [RATE_W-1:0] wr_clamped;

    // Clamp an incoming rate to the frame rate.
    always_comb begin
        wr_clamped = (wr_data > FULL_RATE) ? FULL_RATE : wr_data;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rate
        logic [RATE_W-1:0] rate_q;

        // Hold the programmed rate; accept writes only in variable-rate mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rate_q <= FULL_RATE;
            end else if (wr_en && vra_en && (wr_sel == SEL_W'(g))) begin
                rate_q <= wr_clamped;
            end
        end

        assign eff_rate[g*RATE_W +: RATE_W] = vra_en ? rate_q : FULL_RATE;
    end

endmodule

// File: rtl/vra_phase_acc.sv
// Module: phase accumulator and request bit for one slot.
// At each frame strobe it adds the slot's rate. When the sum reaches the frame
// rate and the FIFO will have room, it requests and subtracts the frame rate.
// A stall keeps the phase untouched.
// Assumes: rate <= FRAME_HZ (clamped upstream), so the sum fits in ACC_W bits.
module vra_phase_acc
    import vra_pkg::*;
#(
    parameter int RATE_W   = 16,
    parameter int FRAME_HZ = 48000,
    parameter int ACC_W    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strb,
    input  logic              vra_en,
    input  logic              active,
    input  logic              room,
    input  logic [RATE_W-1:0] rate,
    output logic              req_n
);

    localparam logic [ACC_W-1:0] WRAP = ACC_W'(FRAME_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             due;
    pace_t            pace;

    // Candidate phase after this frame's increment.
    always_comb begin
        sum = acc_q + ACC_W'(rate);
        due = (sum >= WRAP);
    end

    // Choose this frame's pacing action.
    always_comb begin
        if (!active) begin
            pace = PACE_OFF;
        end else if (!vra_en) begin
            pace = PACE_FORCED;
        end else if (due && room) begin
            pace = PACE_FIRE;
        end else if (due) begin
            pace = PACE_STALL;
        end else begin
            pace = PACE_WAIT;
        end
    end

    // Apply the action at the frame strobe; hold everything between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            req_n <= 1'b1;
        end else if (frame_strb) begin
            case (pace)
                PACE_OFF: begin
                    acc_q <= '0;
                    req_n <= 1'b1;
                end
                PACE_FORCED: begin
                    acc_q <= '0;
                    req_n <= 1'b0;
                end
                PACE_FIRE: begin
                    acc_q <= sum - WRAP;
                    req_n <= 1'b0;
                end
                PACE_STALL: begin
                    req_n <= 1'b1;
                end
                default: begin
                    acc_q <= sum;
                    req_n <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/vra_slot_fifo.sv
// Module: small sample FIFO for one slot.
// A push is accepted when there is a free entry, or when a pop in the same cycle
// frees one. A pop on an empty FIFO is ignored. It also reports whether the
// level after this cycle leaves room for one more sample.
// Assumes: DEPTH >= 1; LVL_W can hold DEPTH.
module vra_slot_fifo #(
    parameter int DATA_W = 20,
    parameter int DEPTH  = 4,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic              push_ok,
    output logic              room_next,
    output logic [DATA_W-1:0] dout,
    output logic [LVL_W-1:0]  level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              pop_ok;
    logic [LVL_W-1:0]  level_nx;

    // Qualify the push and pop requests and form the next level.
    always_comb begin
        pop_ok    = pop && (level != '0);
        push_ok   = push && ((level != FULL) || pop_ok);
        level_nx  = level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        room_next = (level_nx < FULL);
    end

    // Advance pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            level <= level_nx;
        end
    end

    // Store accepted samples.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/vra_slot_pacer.sv
// Module: variable-rate slot request generator (top).
// Once per frame strobe it checks the tags answering last frame's requests,
// stores tagged samples, flags missing ones, and decides the active-low request
// bits for the next input frame from the rates and the FIFO room.
// Assumes: frame_strb is a one-cycle pulse; tag_in and slot_din are valid with it.
module vra_slot_pacer
    import vra_pkg::*;
#(
    parameter int                   NUM_SLOTS  = 2,
    parameter int                   DATA_W     = 20,
    parameter int                   FIFO_DEPTH = 4,
    parameter int                   RATE_W     = 16,
    parameter int                   FRAME_HZ   = 48000,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK  = '1,
    parameter int                   SEL_W      = index_width(NUM_SLOTS),
    parameter int                   LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_strb,
    input  logic                          vra_en,
    input  logic                          rate_we,
    input  logic [SEL_W-1:0]              rate_wsel,
    input  logic [RATE_W-1:0]             rate_wdata,
    input  logic [NUM_SLOTS-1:0]          slot_pdn,
    input  logic [NUM_SLOTS-1:0]          tag_in,
    input  logic [NUM_SLOTS*DATA_W-1:0]   slot_din,
    input  logic [NUM_SLOTS-1:0]          dac_pop,
    output logic [NUM_SLOTS-1:0]          slot_req_n,
    output logic [NUM_SLOTS-1:0]          fifo_wr,
    output logic [NUM_SLOTS*DATA_W-1:0]   dac_dout,
    output logic [NUM_SLOTS*LVL_W-1:0]    fifo_level,
    output logic [NUM_SLOTS-1:0]          underrun
);

    localparam int ACC_W = acc_width(FRAME_HZ);

    logic [NUM_SLOTS*RATE_W-1:0] eff_rate;
    logic [NUM_SLOTS-1:0]        active;

    assign active = SLOT_MASK & ~slot_pdn;

    vra_rate_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .RATE_W    (RATE_W),
        .FRAME_HZ  (FRAME_HZ),
        .SEL_W     (SEL_W)
    ) u_rates (
        .clk      (clk),
        .rst_n    (rst_n),
        .vra_en   (vra_en),
        .wr_en    (rate_we),
        .wr_sel   (rate_wsel),
        .wr_data  (rate_wdata),
        .eff_rate (eff_rate)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic answered;
        logic take;
        logic miss;
        logic push_ok;
        logic room_next;
        logic wr_q;
        logic ur_q;

        // Classify this frame's answer to last frame's request.
        always_comb begin
            answered = frame_strb && active[g] && !slot_req_n[g];
            take     = answered && tag_in[g];
            miss     = answered && !tag_in[g];
        end

        vra_slot_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (FIFO_DEPTH),
            .LVL_W  (LVL_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (take),
            .din       (slot_din[g*DATA_W +: DATA_W]),
            .pop       (dac_pop[g]),
            .push_ok   (push_ok),
            .room_next (room_next),
            .dout      (dac_dout[g*DATA_W +: DATA_W]),
            .level     (fifo_level[g*LVL_W +: LVL_W])
        );

        vra_phase_acc #(
            .RATE_W   (RATE_W),
            .FRAME_HZ (FRAME_HZ),
            .ACC_W    (ACC_W)
        ) u_pace (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_strb (frame_strb),
            .vra_en     (vra_en),
            .active     (active[g]),
            .room       (room_next),
            .rate       (eff_rate[g*RATE_W +: RATE_W]),
            .req_n      (slot_req_n[g])
        );

        // Register the write strobe and the sticky underrun flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q <= 1'b0;
                ur_q <= 1'b0;
            end else begin
                wr_q <= push_ok;
                ur_q <= ur_q || miss;
            end
        end

        assign fifo_wr[g]  = wr_q;
        assign underrun[g] = ur_q;
    end

endmodule

// File: rtl/vra_slot_pacer_chk.sv
// Module: assertion checker for vra_slot_pacer, attached with bind below.
// Assumes: same parameters as the top it is bound into.
module vra_slot_pacer_chk #(
    parameter int                   NUM_SLOTS  = 2,
    parameter int                   FIFO_DEPTH = 4,
    parameter int                   LVL_W      = 3,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK  = '1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_strb,
    input logic                       vra_en,
    input logic [NUM_SLOTS-1:0]       slot_pdn,
    input logic [NUM_SLOTS-1:0]       tag_in,
    input logic [NUM_SLOTS-1:0]       slot_req_n,
    input logic [NUM_SLOTS-1:0]       fifo_wr,
    input logic [NUM_SLOTS*LVL_W-1:0] fifo_level,
    input logic [NUM_SLOTS-1:0]       underrun
);

    logic [NUM_SLOTS-1:0] act_c;
    assign act_c = SLOT_MASK & ~slot_pdn;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strb |=> $stable(slot_req_n));

    // R2
    fixed_rate_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strb && !vra_en) |=> (slot_req_n == ~$past(act_c)));

    // R5
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strb |=> ((~slot_req_n & ~$past(act_c)) == '0));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        // R8
        wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_wr[g] |-> $past(frame_strb && tag_in[g] && !slot_req_n[g]));

        // R9
        underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            underrun[g] |=> underrun[g]);

        // R6
        level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_level[g*LVL_W +: LVL_W] <= LVL_W'(FIFO_DEPTH));
    end

endmodule

bind vra_slot_pacer vra_slot_pacer_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W),
    .SLOT_MASK  (SLOT_MASK)
) u_vra_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_strb (frame_strb),
    .vra_en     (vra_en),
    .slot_pdn   (slot_pdn),
    .tag_in     (tag_in),
    .slot_req_n (slot_req_n),
    .fifo_wr    (fifo_wr),
    .fifo_level (fifo_level),
    .underrun   (underrun)
);

// File: tb/vra_slot_pacer_bench.sv
// Bench: behavioural reference model (queues, integers) compared every clock.
module vra_slot_pacer_bench;

    localparam int N     = 2;
    localparam int DW    = 20;
    localparam int DEPTH = 4;
    localparam int RW    = 16;
    localparam int HZ    = 48000;
    localparam int LW    = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            frame_strb = 1'b0;
    logic            vra_en = 1'b0;
    logic            rate_we = 1'b0;
    logic [0:0]      rate_wsel = '0;
    logic [RW-1:0]   rate_wdata = '0;
    logic [N-1:0]    slot_pdn = '0;
    logic [N-1:0]    tag_in = '0;
    logic [N*DW-1:0] slot_din = '0;
    logic [N-1:0]    dac_pop = '0;
    logic [N-1:0]    slot_req_n;
    logic [N-1:0]    fifo_wr;
    logic [N*DW-1:0] dac_dout;
    logic [N*LW-1:0] fifo_level;
    logic [N-1:0]    underrun;

    vra_slot_pacer u_vra_slot_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_strb (frame_strb),
        .vra_en     (vra_en),
        .rate_we    (rate_we),
        .rate_wsel  (rate_wsel),
        .rate_wdata (rate_wdata),
        .slot_pdn   (slot_pdn),
        .tag_in     (tag_in),
        .slot_din   (slot_din),
        .dac_pop    (dac_pop),
        .slot_req_n (slot_req_n),
        .fifo_wr    (fifo_wr),
        .dac_dout   (dac_dout),
        .fifo_level (fifo_level),
        .underrun   (underrun)
    );

    int    vectors = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // reference model state
    int          m_acc [N];
    int          m_rate [N];
    bit          m_req_n [N];
    bit          m_wr [N];
    bit          m_ur [N];
    logic [DW-1:0] m_q [N][$];

    int tag_mode [N];   // 0 answer requests, 1 always tag, 2 never tag
    int req_cnt [N];
    int wr_cnt [N];
    int r11_bad = 0;
    int seed = 1;
    bit strb_at_edge;
    logic [N-1:0] prev_req = '1;

    task automatic model_step();
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_acc[i] = 0; m_rate[i] = HZ; m_req_n[i] = 1'b1;
                m_wr[i] = 1'b0; m_ur[i] = 1'b0; m_q[i].delete();
            end
            return;
        end
        for (int i = 0; i < N; i++) begin
            bit act, pop_ok, asked, push;
            int sum;
            act    = !slot_pdn[i];
            pop_ok = dac_pop[i] && (m_q[i].size() > 0);
            asked  = frame_strb && act && !m_req_n[i];
            push   = asked && tag_in[i] && ((m_q[i].size() - int'(pop_ok)) < DEPTH);
            if (asked && !tag_in[i]) m_ur[i] = 1'b1;
            if (pop_ok) void'(m_q[i].pop_front());
            if (push) m_q[i].push_back(slot_din[i*DW +: DW]);
            m_wr[i] = push;
            if (frame_strb) begin
                if (!act) begin
                    m_req_n[i] = 1'b1; m_acc[i] = 0;
                end else if (!vra_en) begin
                    m_req_n[i] = 1'b0; m_acc[i] = 0;
                end else begin
                    sum = m_acc[i] + m_rate[i];
                    if (sum >= HZ) begin
                        if (m_q[i].size() < DEPTH) begin
                            m_req_n[i] = 1'b0; m_acc[i] = sum - HZ;
                        end else begin
                            m_req_n[i] = 1'b1;
                        end
                    end else begin
                        m_req_n[i] = 1'b1; m_acc[i] = sum;
                    end
                end
            end
        end
        if (rate_we && vra_en)
            m_rate[int'(rate_wsel)] = (int'(rate_wdata) > HZ) ? HZ : int'(rate_wdata);
    endtask

    task automatic compare();
        bit bad;
        bad = 1'b0;
        vectors++;
        for (int i = 0; i < N; i++) begin
            if (slot_req_n[i] !== m_req_n[i]) begin
                bad = 1'b1;
                $display("FAIL %s slot%0d req_n actual %0b expected %0b", cur_req, i, slot_req_n[i], m_req_n[i]);
            end
            if (fifo_wr[i] !== m_wr[i]) begin
                bad = 1'b1;
                $display("FAIL %s slot%0d fifo_wr actual %0b expected %0b", cur_req, i, fifo_wr[i], m_wr[i]);
            end
            if (int'(fifo_level[i*LW +: LW]) != m_q[i].size()) begin
                bad = 1'b1;
                $display("FAIL %s slot%0d level actual %0d expected %0d", cur_req, i, fifo_level[i*LW +: LW], m_q[i].size());
            end
            if (underrun[i] !== m_ur[i]) begin
                bad = 1'b1;
                $display("FAIL %s slot%0d underrun actual %0b expected %0b", cur_req, i, underrun[i], m_ur[i]);
            end
            if (m_q[i].size() > 0 && dac_dout[i*DW +: DW] !== m_q[i][0]) begin
                bad = 1'b1;
                $display("FAIL %s slot%0d dout actual %0h expected %0h", cur_req, i, dac_dout[i*DW +: DW], m_q[i][0]);
            end
            if (fifo_wr[i]) wr_cnt[i]++;
        end
        // R11: request bits move only at a strobe edge
        if (!strb_at_edge && rst_n && slot_req_n !== prev_req) r11_bad++;
        prev_req = slot_req_n;
        if (bad) errors++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        strb_at_edge = frame_strb;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic frame();
        frame_strb = 1'b1;
        for (int i = 0; i < N; i++)
            tag_in[i] = (tag_mode[i] == 0) ? !m_req_n[i] : (tag_mode[i] == 1);
        slot_din = {DW'(seed * 7 + 2), DW'(seed * 3 + 1)};
        seed++;
        tick();
        frame_strb = 1'b0;
        tag_in = '0;
        repeat (3) tick();
        for (int i = 0; i < N; i++) if (!slot_req_n[i]) req_cnt[i]++;
    endtask

    task automatic write_rate(input int slot, input int val);
        rate_we = 1'b1; rate_wsel = 1'(slot); rate_wdata = RW'(val);
        tick();
        rate_we = 1'b0;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) begin req_cnt[i] = 0; wr_cnt[i] = 0; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) tag_mode[i] = 0;
        clear_counts();
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        check(slot_req_n == 2'b11 && fifo_level == '0 && underrun == '0 && fifo_wr == '0,
              "R1 reset outputs", int'(slot_req_n), 3);
        rst_n = 1'b1;

        // R2: fixed rate, FIFO filling with no drain
        cur_req = "R2";
        repeat (6) frame();
        check(slot_req_n == 2'b00, "R2 req_n with full FIFO", int'(slot_req_n), 0);
        check(fifo_level[LW-1:0] == 3'd4, "R2 slot0 level", int'(fifo_level[LW-1:0]), 4);

        // R10: drain, then pop on empty
        cur_req = "R10";
        dac_pop = 2'b11;
        repeat (7) tick();
        check(fifo_level == '0, "R10 drained and empty pop ignored", int'(fifo_level), 0);

        // R4: write ignored while fixed rate, then clamp above frame rate
        cur_req = "R4";
        write_rate(0, 8000);
        vra_en = 1'b1;
        clear_counts();
        repeat (6) frame();
        check(req_cnt[0] == 6, "R4 ignored write keeps 48000", req_cnt[0], 6);
        write_rate(1, 60000);
        clear_counts();
        repeat (6) frame();
        check(req_cnt[1] == 6, "R4 rate above 48000 every frame", req_cnt[1], 6);

        // R5: power-down clears requests and phase
        cur_req = "R5";
        slot_pdn = 2'b11;
        frame();
        check(slot_req_n == 2'b11, "R5 powered-down req_n", int'(slot_req_n), 3);
        write_rate(0, 44100);
        write_rate(1, 8000);
        slot_pdn = 2'b00;

        // R3 / R7: pacing over 480 frames
        cur_req = "R3";
        clear_counts();
        repeat (480) frame();
        check(req_cnt[0] == 441, "R3 44100 Hz requests in 480 frames", req_cnt[0], 441);
        check(req_cnt[1] == 80, "R3 8000 Hz requests in 480 frames", req_cnt[1], 80);
        check(wr_cnt[0] == 440, "R7 slot0 accepted samples", wr_cnt[0], 440);
        check(wr_cnt[1] == 79, "R7 slot1 accepted samples", wr_cnt[1], 79);

        // R6: full FIFO suppresses requests, one pop resumes
        cur_req = "R6";
        write_rate(0, 48000);
        repeat (3) tick();
        dac_pop[0] = 1'b0;
        repeat (8) frame();
        check(fifo_level[LW-1:0] == 3'd4, "R6 slot0 level at depth", int'(fifo_level[LW-1:0]), 4);
        check(slot_req_n[0] == 1'b1, "R6 request suppressed when full", int'(slot_req_n[0]), 1);
        dac_pop[0] = 1'b1;
        tick();
        dac_pop[0] = 1'b0;
        frame();
        check(slot_req_n[0] == 1'b0, "R6 request resumes after pop", int'(slot_req_n[0]), 0);
        frame();

        // R8: tags on a slot that never asked
        cur_req = "R8";
        write_rate(1, 0);
        tag_mode[1] = 1;
        repeat (2) frame();
        dac_pop[1] = 1'b0;
        clear_counts();
        repeat (4) frame();
        check(wr_cnt[1] == 0, "R8 unrequested tag writes", wr_cnt[1], 0);
        check(fifo_level[2*LW-1:LW] == '0, "R8 slot1 level", int'(fifo_level[2*LW-1:LW]), 0);

        // R9: requested but untagged
        cur_req = "R9";
        dac_pop[0] = 1'b1;
        repeat (4) tick();
        tag_mode[0] = 2;
        repeat (3) frame();
        check(underrun == 2'b01, "R9 underrun set on slot0 only", int'(underrun), 1);
        tag_mode[0] = 0;
        repeat (3) frame();
        check(underrun[0] == 1'b1, "R9 underrun sticky", int'(underrun[0]), 1);

        // R11: request bits moved only at strobe edges
        check(r11_bad == 0, "R11 req_n changes between strobes", r11_bad, 0);
        finish_run();
    end

endmodule